// File: doc/BRIEF.md
# PWM Dithering Frame Controller

This block gives a PWM generator a finer resolution than its counter clock provides. It does this by stretching some frames of a group by one clock. A 2-bit mode input selects one of four settings: pass-through, or a dither group of 16, 32 or 64 frames. In a dither mode, the low N bits of the period value and of the compare value (N = 4, 5 or 6) form a fraction K. The remaining upper bits form the integer value. Across each group of 2^N frames, exactly K frames use the integer value plus one.

The PWM counter sits outside this block. It raises `frame_start` for one clock at the start of each frame. One clock later it reads `eff_period` and `eff_compare`, which hold the values for that frame until the next strobe. Period and compare are handled by two separate lanes, so each lane has its own fraction and its own phase accumulator. A shared frame sequencer tracks the position of the current frame inside the group.

Top module: `pwm_dither_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `eff_period` and `eff_compare` are 0. The first frame after reset is frame 0 of a group.
- R2: The outputs change only in the cycle after a cycle in which `frame_start` is 1. At all other times they hold their value.
- R3: With mode 0 (no dithering), a strobe loads `period_in` and `compare_in` unchanged into `eff_period` and `eff_compare`.
- R4: Mode 1, 2 and 3 use N = 4, 5 and 6 dither bits. Each output equals its input shifted right by N, or that value plus one.
- R5: Within a complete group of 2^N frames, the number of frames with the plus-one value equals K, the value of bits N-1:0 of that input.
- R6: Frame i of the group (i = 0 .. 2^N-1) is extended exactly when floor((i+1)K/2^N) > floor(iK/2^N). Frame 0 is therefore never extended.
- R7: The frame index advances by one on each strobe and wraps from 2^N-1 back to 0, which starts a new group.
- R8: Period and compare are dithered independently. Each output's pattern depends only on its own K.
- R9: A strobe arriving with a mode different from the mode of the previous strobe starts a new group at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-clock strobe at the start of each PWM frame |
| mode | input | 2 | 0 off, 1 group of 16, 2 group of 32, 3 group of 64 |
| period_in | input | VAL_W | Period value: integer in upper bits, fraction in low N bits |
| compare_in | input | VAL_W | Compare value, same format as the period |
| eff_period | output | VAL_W | Period to use for the current frame |
| eff_compare | output | VAL_W | Compare value to use for the current frame |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the outputs hold between strobes;
- in mode 0 the inputs pass through unchanged;
- each output is the integer part or one more than it;
- the first frame of a group is never extended;
- the frame index stays inside the group;
- a mode change restarts the group.

Other properties span many frames and only the bench scenarios can show them. These are the exact count of extended frames per group, the position of each extended frame, the wrap into a second group, and the independence of the two lanes with different fractions. The bench compares every frame against a closed-form floor formula.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

  localparam int MAX_DBITS = 6;
  localparam int IDX_W     = MAX_DBITS;

  typedef enum logic [1:0] {
    DM_OFF = 2'd0,
    DM_G16 = 2'd1,
    DM_G32 = 2'd2,
    DM_G64 = 2'd3
  } dmode_e;

  // number of fractional bits for a mode
  function automatic logic [2:0] dbits(input logic [1:0] m);
    case (m)
      DM_G16:  dbits = 3'd4;
      DM_G32:  dbits = 3'd5;
      DM_G64:  dbits = 3'd6;
      default: dbits = 3'd0;
    endcase
  endfunction

  // mask of the fractional bits for a mode
  function automatic logic [MAX_DBITS-1:0] dmask(input logic [1:0] m);
    logic [MAX_DBITS:0] one_sh;
    one_sh = (MAX_DBITS+1)'(1) << dbits(m);
    dmask  = MAX_DBITS'(one_sh - (MAX_DBITS+1)'(1));
  endfunction

endpackage

// File: rtl/pwm_dither_seq.sv
module pwm_dither_seq
  import pwm_dither_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [1:0]       mode,
  output logic [IDX_W-1:0] cur_idx,
  output logic             restart,
  output logic [IDX_W-1:0] idx_q,
  output logic [1:0]       mode_q
);

  logic             mode_chg;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    mode_chg = (mode != mode_q);
    cur_idx  = mode_chg ? '0 : idx_q;
    restart  = (cur_idx == '0);
    idx_nxt  = (cur_idx + IDX_W'(1)) & dmask(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mode_q <= DM_OFF;
    end else if (step) begin
      idx_q  <= idx_nxt;
      mode_q <= mode;
    end
  end

endmodule

// File: rtl/pwm_dither_lane.sv
module pwm_dither_lane
  import pwm_dither_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int FRAC_W = MAX_DBITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [1:0]       mode,
  input  logic [VAL_W-1:0] value,
  output logic [VAL_W-1:0] eff
);

  logic [2:0]        nb;
  logic [FRAC_W-1:0] fmask;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_base;
  logic [FRAC_W:0]   sum;
  logic              carry;
  logic [VAL_W-1:0]  ipart;
  logic [VAL_W-1:0]  eff_nxt;

  always_comb begin
    nb       = dbits(mode);
    fmask    = FRAC_W'(dmask(mode));
    frac     = value[FRAC_W-1:0] & fmask;
    acc_base = restart ? '0 : acc_q;
    sum      = {1'b0, acc_base} + {1'b0, frac};
    // both operands < 2^N, so the sum shifted by N is 0 or 1
    carry    = |(sum >> nb);
    ipart    = value >> nb;
    eff_nxt  = ipart + VAL_W'(carry);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      eff   <= '0;
    end else if (step) begin
      acc_q <= sum[FRAC_W-1:0] & fmask;
      eff   <= eff_nxt;
    end
  end

endmodule

// File: rtl/pwm_dither_ctrl.sv
module pwm_dither_ctrl
  import pwm_dither_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [1:0]       mode,
  input  logic [VAL_W-1:0] period_in,
  input  logic [VAL_W-1:0] compare_in,
  output logic [VAL_W-1:0] eff_period,
  output logic [VAL_W-1:0] eff_compare
);

  localparam int LANES = 2;

  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] frame_idx;
  logic [1:0]       mode_q;
  logic             grp_start;

  logic [VAL_W-1:0] lane_in  [LANES];
  logic [VAL_W-1:0] lane_out [LANES];

  pwm_dither_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .step    (frame_start),
    .mode    (mode),
    .cur_idx (cur_idx),
    .restart (grp_start),
    .idx_q   (frame_idx),
    .mode_q  (mode_q)
  );

  assign lane_in[0] = period_in;
  assign lane_in[1] = compare_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pwm_dither_lane #(
      .VAL_W  (VAL_W),
      .FRAC_W (MAX_DBITS)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .step    (frame_start),
      .restart (grp_start),
      .mode    (mode),
      .value   (lane_in[g]),
      .eff     (lane_out[g])
    );
  end

  assign eff_period  = lane_out[0];
  assign eff_compare = lane_out[1];

endmodule

// File: rtl/pwm_dither_chk.sv
module pwm_dither_chk
  import pwm_dither_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic [1:0]       mode,
  input logic [VAL_W-1:0] period_in,
  input logic [VAL_W-1:0] compare_in,
  input logic [VAL_W-1:0] eff_period,
  input logic [VAL_W-1:0] eff_compare,
  input logic [IDX_W-1:0] frame_idx,
  input logic [1:0]       mode_q,
  input logic             grp_start
);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (eff_period == '0) && (eff_compare == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(eff_period) && $stable(eff_compare));

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && mode == DM_OFF) |=>
      (eff_period == $past(period_in)) && (eff_compare == $past(compare_in)));

  // R4
  ipart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=>
      ((eff_period - ($past(period_in) >> dbits($past(mode)))) <= VAL_W'(1)) &&
      ((eff_compare - ($past(compare_in) >> dbits($past(mode)))) <= VAL_W'(1)));

  // R6
  first_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && grp_start) |=>
      (eff_period == ($past(period_in) >> dbits($past(mode)))) &&
      (eff_compare == ($past(compare_in) >> dbits($past(mode)))));

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_idx >> dbits(mode_q)) == '0);

  // R9
  mode_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && mode != mode_q) |=>
      frame_idx == (IDX_W'(1) & dmask($past(mode))));

endmodule

bind pwm_dither_ctrl pwm_dither_chk #(.VAL_W(VAL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .mode        (mode),
  .period_in   (period_in),
  .compare_in  (compare_in),
  .eff_period  (eff_period),
  .eff_compare (eff_compare),
  .frame_idx   (frame_idx),
  .mode_q      (mode_q),
  .grp_start   (grp_start)
);

// File: tb/tb_pwm_dither_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_dither_ctrl;

  localparam int VAL_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_start = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [VAL_W-1:0] period_in = '0;
  logic [VAL_W-1:0] compare_in = '0;
  logic [VAL_W-1:0] eff_period;
  logic [VAL_W-1:0] eff_compare;

  always #10 clk = ~clk;

  pwm_dither_ctrl #(.VAL_W(VAL_W)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .mode(mode),
    .period_in(period_in), .compare_in(compare_in),
    .eff_period(eff_period), .eff_compare(eff_compare)
  );

  int checks = 0;
  int errors = 0;

  // scoreboard queues
  logic [VAL_W-1:0] q_exp_p[$];
  logic [VAL_W-1:0] q_exp_c[$];
  logic [VAL_W-1:0] q_base_p[$];
  logic [VAL_W-1:0] q_base_c[$];
  string            q_tag[$];

  int ext_p = 0;
  int ext_c = 0;

  // bench model state
  int m_idx  = 0;
  int m_mode = 0;

  function automatic int nbits_of(input int md);
    return (md == 0) ? 0 : md + 3;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int md, input int p, input int c, input string tag);
    int n, sz, i, kp, kc, xp, xc;
    @(negedge clk);
    n  = nbits_of(md);
    sz = 1 << n;
    i  = (md != m_mode) ? 0 : m_idx;
    kp = p % sz;
    kc = c % sz;
    xp = (((i + 1) * kp) >> n) - ((i * kp) >> n);
    xc = (((i + 1) * kc) >> n) - ((i * kc) >> n);
    q_exp_p.push_back(VAL_W'((p >> n) + xp));
    q_exp_c.push_back(VAL_W'((c >> n) + xc));
    q_base_p.push_back(VAL_W'(p >> n));
    q_base_c.push_back(VAL_W'(c >> n));
    q_tag.push_back(tag);
    m_idx  = (i + 1) % sz;
    m_mode = md;
    mode        = 2'(md);
    period_in   = VAL_W'(p);
    compare_in  = VAL_W'(c);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // full group starting at frame 0; checks the count of extended frames
  task automatic run_group(input int md, input int p, input int c, input string tag);
    int sz;
    sz = 1 << nbits_of(md);
    @(negedge clk);
    ext_p = 0;
    ext_c = 0;
    for (int f = 0; f < sz; f++) frame(md, p, c, tag);
    @(negedge clk);
    // R5: count of extended frames equals the fraction
    check({"R5 period count ", tag}, ext_p, p % sz);
    check({"R5 compare count ", tag}, ext_c, c % sz);
  endtask

  // monitor
  logic fs_seen = 1'b0;
  always @(posedge clk) fs_seen <= frame_start && !rst;

  always @(negedge clk) begin
    if (fs_seen && q_exp_p.size() > 0) begin
      logic [VAL_W-1:0] ep, ec, bp, bc;
      string t;
      ep = q_exp_p.pop_front();
      ec = q_exp_c.pop_front();
      bp = q_base_p.pop_front();
      bc = q_base_c.pop_front();
      t  = q_tag.pop_front();
      check({t, " period"}, eff_period, ep);
      check({t, " compare"}, eff_compare, ec);
      if (eff_period != bp) ext_p++;
      if (eff_compare != bc) ext_c++;
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VAL_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset period", eff_period, 0);
    check("R1 reset compare", eff_compare, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", eff_period, 0);

    // R3: mode 0 pass-through, several patterns
    frame(0, 16'h1234, 16'h00FF, "R3");
    frame(0, 16'hFFFF, 16'h0000, "R3");
    frame(0, 16'h0001, 16'hABCD, "R3");

    // R4 R5 R6 R8: group of 16, different fractions per lane
    run_group(1, 16'h0123, 16'h00AF, "R6 R8 mode1");
    // R4: group of 32, K=0 on period, K=31 on compare
    run_group(2, 16'h0140, 16'h015F, "R4 R6 mode2");
    // group of 64, K=1 and K=63
    run_group(3, 16'h0101, 16'h00FF, "R6 R8 mode3");
    // R7: wrap into a second group, same mode
    run_group(3, 16'h0101, 16'h00FF, "R7 wrap");
    for (int f = 0; f < 3; f++) frame(3, 16'h0120, 16'h0107, "R7 next group");

    // R9: change mode mid-group restarts at frame 0
    for (int f = 0; f < 5; f++) frame(1, 16'h0207, 16'h0109, "R9 pre");
    run_group(2, 16'h0211, 16'h0103, "R9 restart");

    // R2: outputs hold without a strobe
    frame(1, 16'h0305, 16'h0306, "R2 load");
    @(negedge clk);
    held = eff_period;
    period_in  = 16'h7777;
    compare_in = 16'h5555;
    mode       = 2'd2;
    repeat (5) @(negedge clk);
    check("R2 hold period", eff_period, held);
    check("R2 hold compare", eff_compare, VAL_W'(16'h0306 >> 4));

    repeat (3) @(negedge clk);
    check("R5 queue drained", q_exp_p.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule